// File: doc/BRIEF.md
# Serial ADC Device-Side Emulator

This block stands in for the digital face of a 12-bit serial analog-to-digital converter so that a host-side controller can be tested against it. The host drives an active-low chip select, a serial clock and an active-low shutdown line. The emulator takes a parallel sample word as the value it "converts". A falling chip select captures the sample and starts a conversion of programmable length. During the conversion the data line is driven low. At the end of the conversion the line goes high. After that, each falling serial clock edge moves the next result bit onto the line, most significant first, and zeros follow once the last bit is out. High impedance is modelled by deasserting an output enable.

All three control inputs are asynchronous to the system clock. They pass through a synchroniser and an edge detector. Four states control the sequence. IDLE holds the output released. CONVERT drives zero and counts cycles. READY drives the end-of-conversion high. SHIFT presents the result bits.

The transitions are as follows:
- IDLE→CONVERT on an accepted chip-select fall.
- CONVERT→READY when the count expires.
- READY→SHIFT on the first serial clock fall.
- Any busy state→IDLE when chip select is high or shutdown is asserted.

Three sticky flags report misuse:
- serial clock activity during the conversion;
- a serial clock phase that is too short;
- a conversion started before the wake-up interval after shutdown has run out.

Top module: `adc_serial_emu`

## Requirements
- R1: While the synchronised chip select is high, `dout_oe` is 0. Raising chip select in any busy state returns the block to IDLE.
- R2: A chip-select fall that is accepted captures `sample`, sets `dout_oe` to 1 and drives `dout` to 0 for exactly CONV_CYCLES system cycles. A fall is accepted only when shutdown is deasserted.
- R3: When the conversion ends, `dout` is 1 and stays 1 until the first falling serial clock edge.
- R4: Each falling serial clock edge after the end of conversion presents the next bit on `dout`. The bits come out as sample bit 11 down to bit 0, and every later bit is 0.
- R5: Any serial clock edge, rising or falling, seen during CONVERT sets `err_sclk_conv`.
- R6: Inside a sequence, two successive serial clock edges less than MIN_PHASE system cycles apart set `err_phase`.
- R7: `err_not_ready` is set by a chip-select fall that is accepted before shutdown has been deasserted for WAKE_CYCLES cycles. Reset starts the same interval.
- R8: All three flags stay set until the next accepted chip-select fall. That fall clears them, and `err_not_ready` then takes the wake status of that request.
- R9: While shutdown is asserted, chip-select falls are ignored and `dout_oe` stays 0. Asserting shutdown during a sequence returns the block to IDLE.
- R10: Each input passes through SYNC_STAGES flops and then an edge-detect register. A chip-select fall therefore shows on `dout_oe` SYNC_STAGES+1 rising clock edges after the edge that first samples it.
- R11: Reset gives `dout_oe` = 0, all flags 0, and a wake-up interval that has not yet elapsed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low, asynchronous |
| sclk | input | 1 | Serial clock from host, asynchronous |
| shdn_n | input | 1 | Shutdown, active low, asynchronous |
| sample | input | DW | Value captured at conversion start |
| dout | output | 1 | Serial data line value |
| dout_oe | output | 1 | Data line driven (0 = high impedance) |
| err_sclk_conv | output | 1 | Serial clock toggled during conversion |
| err_phase | output | 1 | Serial clock phase shorter than limit |
| err_not_ready | output | 1 | Conversion requested during wake-up |

## Verification
A bad state code or a corrupted conversion counter shows up at once at the data pins. Either `dout_oe` is wrong in the very next cycle, or the low-to-high end-of-conversion edge moves away from the expected cycle. A shift register that loads or shifts wrongly gives a wrong bit three cycles after the falling serial clock edge that should have moved it. Flag errors become visible one cycle after the offending edge leaves the synchroniser. The bench therefore compares every output on every clock against its own model.

// File: rtl/adc_emu_pkg.sv
package adc_emu_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CONV  = 2'd1,
        ST_READY = 2'd2,
        ST_SHIFT = 2'd3
    } emu_state_e;
endpackage

// File: rtl/adc_emu_sync.sv
module adc_emu_sync #(
    parameter int              W       = 3,
    parameter int              STAGES  = 2,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] in_i,
    output logic [W-1:0] lvl_o,
    output logic [W-1:0] prev_o
);
    logic [STAGES-1:0][W-1:0] stg_q;
    logic [W-1:0]             prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg_q[i] <= RST_VAL;
            prev_q <= RST_VAL;
        end else begin
            stg_q[0] <= in_i;
            for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
            prev_q <= stg_q[STAGES-1];
        end
    end

    assign lvl_o  = stg_q[STAGES-1];
    assign prev_o = prev_q;
endmodule

// File: rtl/adc_emu_wake.sv
module adc_emu_wake #(
    parameter int WAKE_CYCLES = 400
) (
    input  logic clk,
    input  logic rst_n,
    input  logic shdn_n_i,
    output logic awake_o
);
    localparam int CW = $clog2(WAKE_CYCLES + 1);
    localparam logic [CW-1:0] LIMIT = CW'(WAKE_CYCLES);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!shdn_n_i) begin
            cnt_q <= '0;
        end else if (cnt_q != LIMIT) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign awake_o = (cnt_q == LIMIT);

    AST_SHDN_CLEARS_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        !shdn_n_i |=> !awake_o); // R7
endmodule

// File: rtl/adc_emu_phase.sv
module adc_emu_phase #(
    parameter int MIN_PHASE = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active_i,
    input  logic edge_i,
    input  logic clear_i,
    output logic err_o
);
    localparam int PW = $clog2(MIN_PHASE + 1);
    localparam logic [PW-1:0] LIMIT = PW'(MIN_PHASE);

    logic [PW-1:0] gap_q;
    logic          seen_q;
    logic          err_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_q  <= '0;
            seen_q <= 1'b0;
            err_q  <= 1'b0;
        end else if (!active_i) begin
            gap_q  <= '0;
            seen_q <= 1'b0;
            if (clear_i) err_q <= 1'b0;
        end else if (edge_i) begin
            if (seen_q && (gap_q < LIMIT)) err_q <= 1'b1;
            seen_q <= 1'b1;
            gap_q  <= PW'(1);
        end else if (gap_q < LIMIT) begin
            gap_q <= gap_q + 1'b1;
        end
    end

    assign err_o = err_q;

    AST_PHASE_ONLY_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_o) |-> $past(active_i && edge_i)); // R6
    AST_PHASE_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> !err_o); // R8
endmodule

// File: rtl/adc_serial_emu.sv
module adc_serial_emu
    import adc_emu_pkg::*;
#(
    parameter int DW          = 12,
    parameter int CONV_CYCLES = 750,
    parameter int MIN_PHASE   = 20,
    parameter int WAKE_CYCLES = 400,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n,
    input  logic          sclk,
    input  logic          shdn_n,
    input  logic [DW-1:0] sample,
    output logic          dout,
    output logic          dout_oe,
    output logic          err_sclk_conv,
    output logic          err_phase,
    output logic          err_not_ready
);
    localparam int CCW = $clog2(CONV_CYCLES + 1);
    localparam logic [CCW-1:0] CONV_LAST = CCW'(CONV_CYCLES - 1);
    localparam int IDX_CS = 0;
    localparam int IDX_SCLK = 1;
    localparam int IDX_SHDN = 2;

    emu_state_e    state_q, state_d;
    logic [CCW-1:0] conv_cnt_q;
    logic [DW-1:0]  shreg_q;
    logic           err_sclk_q, err_nr_q;

    logic [2:0] lvl, prev;
    logic cs_s, shdn_s, cs_fall, sclk_fall, sclk_edge, accept, abort, awake;

    adc_emu_sync #(
        .W       (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b001)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .in_i   ({shdn_n, sclk, cs_n}),
        .lvl_o  (lvl),
        .prev_o (prev)
    );

    assign cs_s      = lvl[IDX_CS];
    assign shdn_s    = lvl[IDX_SHDN];
    assign cs_fall   = prev[IDX_CS] & ~lvl[IDX_CS];
    assign sclk_fall = prev[IDX_SCLK] & ~lvl[IDX_SCLK];
    assign sclk_edge = prev[IDX_SCLK] ^ lvl[IDX_SCLK];
    assign accept    = cs_fall & shdn_s;
    assign abort     = cs_s | ~shdn_s;

    adc_emu_wake #(.WAKE_CYCLES(WAKE_CYCLES)) u_wake (
        .clk      (clk),
        .rst_n    (rst_n),
        .shdn_n_i (shdn_s),
        .awake_o  (awake)
    );

    adc_emu_phase #(.MIN_PHASE(MIN_PHASE)) u_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .active_i (state_q != ST_IDLE),
        .edge_i   (sclk_edge),
        .clear_i  ((state_q == ST_IDLE) && accept),
        .err_o    (err_phase)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (accept) state_d = ST_CONV;
            ST_CONV:  if (abort) state_d = ST_IDLE;
                      else if (conv_cnt_q == CONV_LAST) state_d = ST_READY;
            ST_READY: if (abort) state_d = ST_IDLE;
                      else if (sclk_fall) state_d = ST_SHIFT;
            ST_SHIFT: if (abort) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // datapath and flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            conv_cnt_q <= '0;
            shreg_q    <= '0;
            err_sclk_q <= 1'b0;
            err_nr_q   <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (accept) begin
                    conv_cnt_q <= '0;
                    shreg_q    <= sample;
                    err_sclk_q <= 1'b0;
                    err_nr_q   <= ~awake;
                end
                ST_CONV: begin
                    conv_cnt_q <= conv_cnt_q + 1'b1;
                    if (sclk_edge) err_sclk_q <= 1'b1;
                end
                ST_SHIFT: if (!abort && sclk_fall) shreg_q <= {shreg_q[DW-2:0], 1'b0};
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        dout_oe = 1'b1;
        dout    = 1'b0;
        unique case (state_q)
            ST_IDLE:  dout_oe = 1'b0;
            ST_CONV:  dout    = 1'b0;
            ST_READY: dout    = 1'b1;
            ST_SHIFT: dout    = shreg_q[DW-1];
            default:  dout_oe = 1'b0;
        endcase
    end

    assign err_sclk_conv = err_sclk_q;
    assign err_not_ready = err_nr_q;

    AST_CS_HIGH_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        cs_s |=> !dout_oe); // R1
    AST_START_DRIVES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dout_oe) |-> !dout); // R2
    AST_CONV_FULL_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_q) == ST_CONV && state_q == ST_READY) |-> $past(conv_cnt_q) == CONV_LAST); // R2
    AST_SCLK_IN_CONV: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CONV && sclk_edge) |=> err_sclk_conv); // R5
    AST_SHDN_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        !shdn_s |=> !dout_oe); // R9
endmodule

// File: tb/adc_serial_emu_bench.sv
module adc_serial_emu_bench;
    localparam int DW = 12;
    localparam int CONV = 750;
    localparam int MINP = 20;
    localparam int WAKE = 400;
    localparam int SYNC = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, sclk = 1'b0, shdn_n = 1'b1;
    logic [DW-1:0] sample = '0;
    logic dout, dout_oe, err_sclk_conv, err_phase, err_not_ready;

    int n_chk = 0, n_fail = 0;

    always #5 clk = ~clk;

    adc_serial_emu #(.DW(DW), .CONV_CYCLES(CONV), .MIN_PHASE(MINP),
                     .WAKE_CYCLES(WAKE), .SYNC_STAGES(SYNC)) u_adc_serial_emu (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .shdn_n(shdn_n),
        .sample(sample), .dout(dout), .dout_oe(dout_oe),
        .err_sclk_conv(err_sclk_conv), .err_phase(err_phase),
        .err_not_ready(err_not_ready));

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    typedef struct packed { logic shdn; logic sk; logic cs; } in_t;
    in_t hist[$];
    int m_st, m_cnt, m_wake, m_gap;
    bit m_seen, m_es, m_ep, m_enr;
    logic [DW-1:0] m_sh;

    always @(posedge clk) begin
        if (!rst_n) begin
            hist = {};
            for (int i = 0; i < SYNC + 2; i++) hist.push_back(in_t'(3'b001));
            m_st = 0; m_cnt = 0; m_wake = 0; m_gap = 0;
            m_seen = 0; m_es = 0; m_ep = 0; m_enr = 0; m_sh = '0;
        end else begin
            in_t cur, prv;
            int ost;
            bit awake, fall, sfall, sedge, abrt;
            hist.push_back(in_t'({shdn_n, sclk, cs_n}));
            cur = hist[hist.size()-1-SYNC];
            prv = hist[hist.size()-2-SYNC];
            void'(hist.pop_front());
            ost = m_st;
            awake = (m_wake >= WAKE);
            fall = prv.cs && !cur.cs;
            sfall = prv.sk && !cur.sk;
            sedge = prv.sk != cur.sk;
            abrt = cur.cs || !cur.shdn;
            if (!cur.shdn) m_wake = 0; else if (m_wake < WAKE) m_wake++;
            if (ost == 0) begin m_seen = 0; m_gap = 0; end
            else if (sedge) begin
                if (m_seen && m_gap < MINP) m_ep = 1;
                m_seen = 1; m_gap = 1;
            end else if (m_gap < MINP) m_gap++;
            case (ost)
                0: if (fall && cur.shdn) begin
                    m_st = 1; m_cnt = 0; m_sh = sample;
                    m_es = 0; m_ep = 0; m_enr = !awake;
                end
                1: begin
                    if (sedge) m_es = 1;
                    if (abrt) m_st = 0;
                    else if (m_cnt == CONV - 1) m_st = 2;
                    m_cnt++;
                end
                2: if (abrt) m_st = 0; else if (sfall) m_st = 3;
                default: if (abrt) m_st = 0; else if (sfall) m_sh = m_sh << 1;
            endcase
        end
    end

    bit cmp_on = 0;
    always @(negedge clk) begin
        if (cmp_on && rst_n) begin
            string tag;
            tag = (m_st == 0) ? "R1" : (m_st == 1) ? "R2" : (m_st == 2) ? "R3" : "R4";
            check({tag, " oe"}, dout_oe, m_st != 0);
            if (m_st != 0)
                check({tag, " dout"}, dout, (m_st == 2) ? 1 : (m_st == 3) ? m_sh[DW-1] : 0);
            check("R5 err_sclk_conv", err_sclk_conv, m_es);
            check("R6 err_phase", err_phase, m_ep);
            check("R7 err_not_ready", err_not_ready, m_enr);
        end
    end

    // ---------------- stimulus ----------------
    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic read_word(int half, output logic [15:0] w);
        w = '0;
        for (int i = 0; i < 16; i++) begin
            sclk = 1'b1; tick(half);
            sclk = 1'b0; tick(half);
            w = {w[14:0], dout};
        end
    endtask

    task automatic full_read(logic [DW-1:0] val);
        logic [15:0] w;
        int lowlen;
        sample = val;
        cs_n = 1'b0;
        tick(2);
        check("R10 oe still low after two edges", dout_oe, 0);
        tick(1);
        check("R10 oe high after third edge", dout_oe, 1);
        lowlen = 0;
        while (dout == 1'b0 && lowlen < CONV + 5) begin lowlen++; tick(1); end
        check("R2 conversion length", lowlen, CONV);
        tick(10);
        check("R3 end of conversion high", dout, 1);
        read_word(25, w);
        check("R4 shifted word", w, {val, 4'b0000});
        cs_n = 1'b1; tick(5);
        check("R1 release after cs high", dout_oe, 0);
    endtask

    task automatic run();
        logic [15:0] w;
        tick(3);
        check("R11 oe in reset", dout_oe, 0);
        check("R11 flags in reset", {err_sclk_conv, err_phase, err_not_ready}, 0);
        rst_n = 1'b1; cmp_on = 1;
        // R7: immediate request after reset is not ready
        sample = 12'h123; cs_n = 1'b0; tick(10);
        check("R7 not ready after reset", err_not_ready, 1);
        cs_n = 1'b1; tick(WAKE + 20);
        full_read(12'hA5C);
        check("R8 flags cleared by new start", {err_sclk_conv, err_phase, err_not_ready}, 0);
        full_read(12'h001);
        full_read(12'hFFF);
        // R5: clock toggled during conversion
        sample = 12'h3C3; cs_n = 1'b0; tick(100);
        sclk = 1'b1; tick(30); sclk = 1'b0; tick(CONV);
        check("R5 sclk during conversion", err_sclk_conv, 1);
        read_word(25, w);
        check("R4 word after conv error", w, {12'h3C3, 4'b0000});
        cs_n = 1'b1; tick(5);
        check("R8 flag sticky after release", err_sclk_conv, 1);
        // R6: short phases
        sample = 12'h5A5; cs_n = 1'b0; tick(CONV + 20);
        check("R8 start cleared conv error", err_sclk_conv, 0);
        read_word(5, w);
        check("R6 short phase flagged", err_phase, 1);
        check("R4 word at fast clock", w, {12'h5A5, 4'b0000});
        cs_n = 1'b1; tick(5);
        // R1: abort in the middle of conversion
        sample = 12'h0F0; cs_n = 1'b0; tick(200);
        check("R2 oe during conversion", dout_oe, 1);
        cs_n = 1'b1; tick(4);
        check("R1 abort in conversion", dout_oe, 0);
        tick(CONV);
        check("R1 stays idle after abort", dout_oe, 0);
        // R9: shutdown ignores chip select
        shdn_n = 1'b0; tick(5);
        cs_n = 1'b0; tick(CONV + 20);
        check("R9 cs ignored in shutdown", dout_oe, 0);
        cs_n = 1'b1; tick(5);
        shdn_n = 1'b1; tick(5);
        sample = 12'h777; cs_n = 1'b0; tick(10);
        check("R7 request during wake-up", err_not_ready, 1);
        check("R8 phase flag cleared", err_phase, 0);
        cs_n = 1'b1; tick(WAKE + 20);
        full_read(12'h6B9);
        check("R8 not-ready cleared", err_not_ready, 0);
        // R9: shutdown during shifting
        sample = 12'hC31; cs_n = 1'b0; tick(CONV + 20);
        for (int i = 0; i < 3; i++) begin sclk = 1'b1; tick(25); sclk = 1'b0; tick(25); end
        check("R4 third bit", dout, 0);
        shdn_n = 1'b0; tick(4);
        check("R9 shutdown aborts shift", dout_oe, 0);
        cs_n = 1'b1; shdn_n = 1'b1; tick(20);
    endtask

    initial begin
        bit wd;
        wd = 0;
        fork
            run();
            begin tick(150000); wd = 1; end
        join_any
        disable fork;
        if (wd) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=expired expected=done");
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule